// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block gives each CPU of a small multiprocessor two inter-processor interrupt channels, named "other" and "self". Every CPU reaches the block through one shared request port. Each request carries the index of the CPU making it. One page of registers acts on the requesting CPU (the local view). A second page has one 128-byte window per CPU (the explicit views), so any CPU can act on any other.

Through these registers software can:
- send the "other" interrupt to any set of CPUs given as a bitmap,
- acknowledge pending interrupts,
- set and clear a mask for each channel,
- read its own CPU index,
- read an event word that reports the highest-priority unmasked pending channel.

Reading the event word masks the channel it reports. The handler acknowledges the interrupt and then clears the mask again. For every CPU the block also drives a registered interrupt line and a channel indicator.

Top module: `ipi_unit`

## Requirements
- R1: After a synchronous reset every pending flag is clear, both channels of every CPU are masked, all interrupt lines are low and event reads return 0.
- R2: A write to local offset 0x2008 raises the "other" pending flag on every CPU c whose data bit c is 1. A flag raised while its channel is masked stays latched and raises the line once the mask is cleared.
- R3: A write to local offset 0x200C clears the requester's "other" pending flag when data bit 0 is 1, and its "self" pending flag when data bit 31 is 1. Zero bits have no effect.
- R4: A write to local offset 0x2024 masks, and a write to 0x2028 unmasks, the requester's "other" channel (bit 0) and "self" channel (bit 31). irq_o[c] is high exactly when some channel of CPU c is pending and unmasked. Idle cycles leave irq_o and irq_chan unchanged.
- R5: A read of local offset 0x2004 returns 0x00040001 for "other", 0x00040002 for "self", or 0 when nothing is deliverable. rd_data and rd_valid appear in the cycle after the request.
- R6: An event read that reports a channel sets that channel's mask and leaves its pending flag set.
- R7: When both channels are deliverable, "other" wins. irq_chan[c] is 0 for "other" and 1 for "self".
- R8: A read of local offset 0x2000 returns the requesting CPU's index.
- R9: Writes to 0x5000 + c*128 + {0x08, 0x0C, 0x24, 0x28} set pending, clear pending, set mask and clear mask for CPU c, with bit 0 for "other" and bit 31 for "self". Windows with c >= NCPU are ignored.
- R10: Bit 31 of a per-CPU set-pending write raises "self" only when the requester is c. From any other CPU that bit is ignored.
- R11: Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cpu | input | CW | Index of the requesting CPU |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | AW | Byte offset |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Read data, one cycle after the read |
| rd_valid | output | 1 | Marks rd_data |
| irq_o | output | NCPU | Per-CPU interrupt line |
| irq_chan | output | NCPU | Winning channel per CPU (0 other, 1 self) |

## Verification
The bench targets four cases:
- **Send to a masked CPU, then unmask.** A design that drops the latched flag never raises the line.
- **Two event reads in a row with both channels deliverable.** A design with the wrong priority reports "self" first. A design that skips the auto-mask reports the same channel twice.
- **A "self" set written by a foreign CPU.** A design that does not check the requester creates a spurious interrupt.
- **A per-CPU window past the last CPU, with CPU 0 unmasked.** A design that wraps the index raises CPU 0.

Zero bits in acknowledge writes and reads of unmapped offsets must leave every line untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // page selectors (addr[15:12])
  localparam logic [3:0] PAGE_LOCAL = 4'h2;
  localparam logic [3:0] PAGE_PERCPU = 4'h5;
  // local page offsets (addr[11:0])
  localparam logic [11:0] LOC_WHOAMI = 12'h000;
  localparam logic [11:0] LOC_EVENT = 12'h004;
  localparam logic [11:0] LOC_SEND = 12'h008;
  localparam logic [11:0] LOC_ACK = 12'h00C;
  localparam logic [11:0] LOC_MSET = 12'h024;
  localparam logic [11:0] LOC_MCLR = 12'h028;
  // per-CPU window offsets (addr[6:0])
  localparam logic [6:0] WIN_SET = 7'h08;
  localparam logic [6:0] WIN_CLR = 7'h0C;
  localparam logic [6:0] WIN_MSET = 7'h24;
  localparam logic [6:0] WIN_MCLR = 7'h28;
  // channel bits in ack / mask / window data
  localparam int BIT_OTHER = 0;
  localparam int BIT_SELF = 31;
  // event word
  localparam logic [15:0] EVT_KIND_IPI = 16'd4;
  localparam logic [15:0] EVT_NUM_OTHER = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF = 16'd2;
  localparam logic [31:0] EVT_WORD_OTHER = {EVT_KIND_IPI, EVT_NUM_OTHER};
  localparam logic [31:0] EVT_WORD_SELF = {EVT_KIND_IPI, EVT_NUM_SELF};

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_WHOAMI,
    RSEL_EVENT
  } rd_sel_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [CW-1:0]   cpu_id,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [NCPU-1:0] set_oth,
  output logic [NCPU-1:0] set_slf,
  output logic [NCPU-1:0] clr_oth,
  output logic [NCPU-1:0] clr_slf,
  output logic [NCPU-1:0] mset_oth,
  output logic [NCPU-1:0] mset_slf,
  output logic [NCPU-1:0] mclr_oth,
  output logic [NCPU-1:0] mclr_slf,
  output logic [NCPU-1:0] take,
  output rd_sel_e         rd_sel
);
  logic [3:0]  page;
  logic [11:0] loc_off;
  logic [4:0]  win_idx;
  logic [6:0]  win_off;
  logic        is_loc;
  logic        win_ok;
  logic        bo;
  logic        bs;

  assign page    = addr[15:12];
  assign loc_off = addr[11:0];
  assign win_idx = addr[11:7];
  assign win_off = addr[6:0];
  assign is_loc  = (page == PAGE_LOCAL);
  assign win_ok  = (page == PAGE_PERCPU) && (int'(win_idx) < NCPU);
  assign bo      = wdata[BIT_OTHER];
  assign bs      = wdata[BIT_SELF];

  always_comb begin
    rd_sel = RSEL_NONE;
    if (rd && is_loc) begin
      if (loc_off == LOC_WHOAMI) rd_sel = RSEL_WHOAMI;
      else if (loc_off == LOC_EVENT) rd_sel = RSEL_EVENT;
    end
  end

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    logic me;
    logic win_me;
    logic loc_me;
    assign me     = (32'(cpu_id) == k);
    assign loc_me = wr && is_loc && me;
    assign win_me = wr && win_ok && (int'(win_idx) == k);

    assign set_oth[k]  = (wr && is_loc && loc_off == LOC_SEND && wdata[k])
                       || (win_me && win_off == WIN_SET && bo);
    assign set_slf[k]  = win_me && win_off == WIN_SET && bs && me;
    assign clr_oth[k]  = bo && ((loc_me && loc_off == LOC_ACK) || (win_me && win_off == WIN_CLR));
    assign clr_slf[k]  = bs && ((loc_me && loc_off == LOC_ACK) || (win_me && win_off == WIN_CLR));
    assign mset_oth[k] = bo && ((loc_me && loc_off == LOC_MSET) || (win_me && win_off == WIN_MSET));
    assign mset_slf[k] = bs && ((loc_me && loc_off == LOC_MSET) || (win_me && win_off == WIN_MSET));
    assign mclr_oth[k] = bo && ((loc_me && loc_off == LOC_MCLR) || (win_me && win_off == WIN_MCLR));
    assign mclr_slf[k] = bs && ((loc_me && loc_off == LOC_MCLR) || (win_me && win_off == WIN_MCLR));
    assign take[k]     = (rd_sel == RSEL_EVENT) && me;
  end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice (
  input  logic clk,
  input  logic rst,
  input  logic set_oth,
  input  logic set_slf,
  input  logic clr_oth,
  input  logic clr_slf,
  input  logic mset_oth,
  input  logic mset_slf,
  input  logic mclr_oth,
  input  logic mclr_slf,
  input  logic take,
  output logic act_oth,
  output logic act_slf,
  output logic irq_q,
  output logic chan_q
);
  logic po, ps, mo, ms;
  logic po_n, ps_n, mo_n, ms_n;
  logic go_n, gs_n;

  assign act_oth = po && !mo;
  assign act_slf = ps && !ms;

  always_comb begin
    po_n = po;
    ps_n = ps;
    mo_n = mo;
    ms_n = ms;
    if (set_oth) po_n = 1'b1;
    if (clr_oth) po_n = 1'b0;
    if (set_slf) ps_n = 1'b1;
    if (clr_slf) ps_n = 1'b0;
    if (mset_oth) mo_n = 1'b1;
    if (mclr_oth) mo_n = 1'b0;
    if (mset_slf) ms_n = 1'b1;
    if (mclr_slf) ms_n = 1'b0;
    // delivery masks the winning channel; pending is left for the ack
    if (take) begin
      if (act_oth) mo_n = 1'b1;
      else if (act_slf) ms_n = 1'b1;
    end
    go_n = po_n && !mo_n;
    gs_n = ps_n && !ms_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      po     <= 1'b0;
      ps     <= 1'b0;
      mo     <= 1'b1;
      ms     <= 1'b1;
      irq_q  <= 1'b0;
      chan_q <= 1'b0;
    end else begin
      po     <= po_n;
      ps     <= ps_n;
      mo     <= mo_n;
      ms     <= ms_n;
      irq_q  <= go_n || gs_n;
      chan_q <= !go_n && gs_n;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   req_cpu,
  input  logic            req_wr,
  input  logic            req_rd,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [NCPU-1:0] irq_o,
  output logic [NCPU-1:0] irq_chan
);
  logic [NCPU-1:0] set_oth, set_slf, clr_oth, clr_slf;
  logic [NCPU-1:0] mset_oth, mset_slf, mclr_oth, mclr_slf, take;
  logic [NCPU-1:0] act_oth, act_slf;
  rd_sel_e         rd_sel;
  logic [31:0]     evt_word;
  logic [DW-1:0]   rd_next;

  ipi_decode #(.NCPU(NCPU), .AW(AW), .DW(DW), .CW(CW)) u_dec (
    .cpu_id  (req_cpu),
    .wr      (req_wr),
    .rd      (req_rd),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .set_oth (set_oth),
    .set_slf (set_slf),
    .clr_oth (clr_oth),
    .clr_slf (clr_slf),
    .mset_oth(mset_oth),
    .mset_slf(mset_slf),
    .mclr_oth(mclr_oth),
    .mclr_slf(mclr_slf),
    .take    (take),
    .rd_sel  (rd_sel)
  );

  for (genvar k = 0; k < NCPU; k++) begin : g_slice
    ipi_cpu_slice u_slice (
      .clk     (clk),
      .rst     (rst),
      .set_oth (set_oth[k]),
      .set_slf (set_slf[k]),
      .clr_oth (clr_oth[k]),
      .clr_slf (clr_slf[k]),
      .mset_oth(mset_oth[k]),
      .mset_slf(mset_slf[k]),
      .mclr_oth(mclr_oth[k]),
      .mclr_slf(mclr_slf[k]),
      .take    (take[k]),
      .act_oth (act_oth[k]),
      .act_slf (act_slf[k]),
      .irq_q   (irq_o[k]),
      .chan_q  (irq_chan[k])
    );
  end

  always_comb begin
    evt_word = '0;
    if (act_oth[req_cpu]) evt_word = EVT_WORD_OTHER;
    else if (act_slf[req_cpu]) evt_word = EVT_WORD_SELF;
    case (rd_sel)
      RSEL_WHOAMI: rd_next = DW'(req_cpu);
      RSEL_EVENT:  rd_next = DW'(evt_word);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_next;
      rd_valid <= req_rd;
    end
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NCPU = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   req_cpu,
  input logic            req_wr,
  input logic            req_rd,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   rd_data,
  input logic            rd_valid,
  input logic [NCPU-1:0] irq_o,
  input logic [NCPU-1:0] irq_chan
);
  logic rd_evt;
  assign rd_evt = req_rd && (req_addr == AW'(16'h2004));

  p_rd_valid_r5: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rd_valid);

  p_whoami_r8: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == AW'(16'h2000)) |=> rd_data == DW'($past(req_cpu)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!req_wr && !req_rd) |=> ($stable(irq_o) && $stable(irq_chan)));

  for (genvar k = 0; k < NCPU; k++) begin : g_k
    p_evt_other_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_evt && req_cpu == CW'(k) && irq_o[k] && !irq_chan[k])
        |=> rd_data == DW'(32'h0004_0001));

    p_evt_self_masks_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_evt && req_cpu == CW'(k) && irq_o[k] && irq_chan[k])
        |=> (rd_data == DW'(32'h0004_0002) && !irq_o[k]));

    p_evt_none_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_evt && req_cpu == CW'(k) && !irq_o[k]) |=> rd_data == '0);
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NCPU(NCPU), .AW(AW), .DW(DW)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .req_cpu (req_cpu),
  .req_wr  (req_wr),
  .req_rd  (req_rd),
  .req_addr(req_addr),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .irq_o   (irq_o),
  .irq_chan(irq_chan)
);

// File: tb/test_ipi_unit.sv
module test_ipi_unit;
  localparam int N = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] req_cpu = '0;
  logic          req_wr = 1'b0;
  logic          req_rd = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic [N-1:0]  irq_o;
  logic [N-1:0]  irq_chan;

  ipi_unit #(.NCPU(N), .AW(16), .DW(32)) i_ipi_unit (
    .clk(clk), .rst(rst), .req_cpu(req_cpu), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_o(irq_o), .irq_chan(irq_chan)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string phase = "R1";

  // behavioural reference model
  bit           m_po[N], m_ps[N], m_mo[N], m_ms[N];
  logic [31:0]  e_rd = '0;
  logic         e_rv = 1'b0;
  logic [N-1:0] e_irq = '0;
  logic [N-1:0] e_chan = '0;
  bit           ready = 0;

  always @(posedge clk) begin
    int me;
    int t;
    me = int'(req_cpu);
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        m_po[k] = 0; m_ps[k] = 0; m_mo[k] = 1; m_ms[k] = 1;
      end
      e_rd = '0;
      e_rv = 1'b0;
    end else begin
      e_rv = req_rd;
      e_rd = '0;
      if (req_rd && req_addr == 16'h2000) e_rd = 32'(me);
      if (req_rd && req_addr == 16'h2004) begin
        if (m_po[me] && !m_mo[me]) begin
          e_rd = 32'h0004_0001; m_mo[me] = 1;
        end else if (m_ps[me] && !m_ms[me]) begin
          e_rd = 32'h0004_0002; m_ms[me] = 1;
        end
      end
      if (req_wr) begin
        if (req_addr == 16'h2008) begin
          for (int k = 0; k < N; k++) if (req_wdata[k]) m_po[k] = 1;
        end else if (req_addr == 16'h200C) begin
          if (req_wdata[0]) m_po[me] = 0;
          if (req_wdata[31]) m_ps[me] = 0;
        end else if (req_addr == 16'h2024) begin
          if (req_wdata[0]) m_mo[me] = 1;
          if (req_wdata[31]) m_ms[me] = 1;
        end else if (req_addr == 16'h2028) begin
          if (req_wdata[0]) m_mo[me] = 0;
          if (req_wdata[31]) m_ms[me] = 0;
        end else if (req_addr[15:12] == 4'h5 && int'(req_addr[11:7]) < N) begin
          t = int'(req_addr[11:7]);
          case (req_addr[6:0])
            7'h08: begin
              if (req_wdata[0]) m_po[t] = 1;
              if (req_wdata[31] && t == me) m_ps[t] = 1;
            end
            7'h0C: begin
              if (req_wdata[0]) m_po[t] = 0;
              if (req_wdata[31]) m_ps[t] = 0;
            end
            7'h24: begin
              if (req_wdata[0]) m_mo[t] = 1;
              if (req_wdata[31]) m_ms[t] = 1;
            end
            7'h28: begin
              if (req_wdata[0]) m_mo[t] = 0;
              if (req_wdata[31]) m_ms[t] = 0;
            end
            default: ;
          endcase
        end
      end
    end
    for (int k = 0; k < N; k++) begin
      e_irq[k]  = (m_po[k] && !m_mo[k]) || (m_ps[k] && !m_ms[k]);
      e_chan[k] = !(m_po[k] && !m_mo[k]) && (m_ps[k] && !m_ms[k]);
    end
    ready = 1;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (ready) begin
      n_cmp++;
      if (rd_data !== e_rd || rd_valid !== e_rv || irq_o !== e_irq || irq_chan !== e_chan) begin
        n_bad++;
        $display("FAIL %s model: rd %h/%b irq %b chan %b expected rd %h/%b irq %b chan %b",
                 phase, rd_data, rd_valid, irq_o, irq_chan, e_rd, e_rv, e_irq, e_chan);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_op(input int cpu, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_cpu = CW'(cpu); req_addr = a; req_wdata = d; req_wr = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd_op(input int cpu, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_cpu = CW'(cpu); req_addr = a; req_rd = 1'b1;
    @(negedge clk);
    d = rd_data;
    req_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    phase = "R1";
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    wr_op(0, 16'h2028, 32'h8000_0001);
    chk("R1 unmask with nothing pending", 32'(irq_o), 32'h0);
    rd_op(0, 16'h2004, d);
    chk("R1 event empty", d, 32'h0);
    wr_op(0, 16'h2024, 32'h8000_0001);
    // R2 send to masked CPUs latches
    phase = "R2";
    wr_op(0, 16'h2008, 32'h6);
    chk("R2 masked send silent", 32'(irq_o), 32'h0);
    wr_op(1, 16'h2028, 32'h1);
    chk("R2 delivered after unmask", 32'(irq_o), 32'h2);
    chk("R7 chan other", 32'(irq_chan[1]), 32'h0);
    // R5 / R6 event read
    phase = "R5";
    rd_op(1, 16'h2004, d);
    chk("R5 other word", d, 32'h0004_0001);
    chk("R6 auto mask drops line", 32'(irq_o[1]), 32'h0);
    rd_op(1, 16'h2004, d);
    chk("R5 no second event", d, 32'h0);
    wr_op(1, 16'h2028, 32'h1);
    chk("R6 pending kept across auto mask", 32'(irq_o[1]), 32'h1);
    // R3 ack
    phase = "R3";
    wr_op(1, 16'h200C, 32'h7FFF_FFFE);
    chk("R3 zero bits no effect", 32'(irq_o[1]), 32'h1);
    wr_op(1, 16'h200C, 32'h1);
    chk("R3 ack clears", 32'(irq_o[1]), 32'h0);
    // R9 / R7 self and priority on CPU 2
    phase = "R7";
    wr_op(2, 16'h5108, 32'h8000_0000);
    wr_op(2, 16'h2028, 32'h8000_0000);
    chk("R9 self via own window", 32'(irq_o[2]), 32'h1);
    chk("R9 self chan", 32'(irq_chan[2]), 32'h1);
    wr_op(2, 16'h2028, 32'h1);
    chk("R7 other wins", 32'(irq_chan[2]), 32'h0);
    rd_op(2, 16'h2004, d);
    chk("R7 first event other", d, 32'h0004_0001);
    chk("R6 self remains", 32'(irq_chan[2]), 32'h1);
    rd_op(2, 16'h2004, d);
    chk("R5 self word", d, 32'h0004_0002);
    chk("R6 both masked", 32'(irq_o[2]), 32'h0);
    // R10 foreign self bit ignored
    phase = "R10";
    wr_op(0, 16'h5188, 32'h8000_0000);
    wr_op(3, 16'h2028, 32'h8000_0001);
    chk("R10 foreign self ignored", 32'(irq_o[3]), 32'h0);
    phase = "R9";
    wr_op(0, 16'h5188, 32'h1);
    chk("R9 window set other", 32'(irq_o[3]), 32'h1);
    wr_op(0, 16'h518C, 32'h1);
    chk("R9 window clear", 32'(irq_o[3]), 32'h0);
    wr_op(0, 16'h5188, 32'h1);
    wr_op(0, 16'h51A4, 32'h1);
    chk("R9 window mask set", 32'(irq_o[3]), 32'h0);
    wr_op(0, 16'h51A8, 32'h1);
    chk("R9 window mask clear", 32'(irq_o[3]), 32'h1);
    wr_op(3, 16'h200C, 32'h1);
    wr_op(0, 16'h2028, 32'h1);
    wr_op(0, 16'h5208, 32'h1);
    chk("R9 window beyond last CPU ignored", 32'(irq_o), 32'h0);
    // R11 unmapped
    phase = "R11";
    wr_op(0, 16'h2010, 32'hFFFF_FFFF);
    chk("R11 unmapped write", 32'(irq_o), 32'h0);
    rd_op(0, 16'h2010, d);
    chk("R11 unmapped read", d, 32'h0);
    // R8 whoami
    phase = "R8";
    for (int c = 0; c < N; c++) begin
      rd_op(c, 16'h2000, d);
      chk("R8 whoami", d, 32'(c));
    end
    // R4 self on CPU 0 then mask via local
    phase = "R4";
    wr_op(0, 16'h5008, 32'h8000_0000);
    wr_op(0, 16'h2028, 32'h8000_0000);
    chk("R4 line for self", 32'(irq_o), 32'h1);
    chk("R4 chan self", 32'(irq_chan[0]), 32'h1);
    wr_op(0, 16'h2024, 32'h8000_0000);
    chk("R4 local mask set", 32'(irq_o[0]), 32'h0);
    // R1 reset mid-run
    phase = "R1";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wr_op(0, 16'h2028, 32'h8000_0001);
    chk("R1 pending cleared by reset", 32'(irq_o), 32'h0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule